// File: doc/BRIEF.md
# Teletext Byte Check and Repair Unit

This unit sits between the data slicer and the page store of a teletext receiver. It looks at every received byte before it is written. A one-bit type select tells it how the byte is protected.

Address and control bytes carry a four-bit value inside an 8-bit Hamming codeword. A single flipped bit is repaired. Two flipped bits are detected but cannot be repaired.

Display bytes carry seven character bits and one parity bit. A byte that cannot be trusted, from either path, is replaced with a blank character, so the screen never shows a wrong symbol.

Each result leaves the unit one cycle after the byte enters, with its own valid strobe. Two pulses go with each result: one says the byte was repaired, the other says it was uncorrectable. Error counters elsewhere can count these pulses.

A per-line health flag is forced high by the line-start pulse. It drops on the first corrupt byte of the line and then stays low, which shows how busy the repair logic is on that line.

Top module: `txt_byte_guard`

## Requirements
- R1: A display byte (`in_ham`=0) whose eight bits have odd parity (bit 7 is the parity bit) produces `out_byte` = {0, in_byte[6:0]}, with `out_fixed`=0 and `out_bad`=0.
- R2: A display byte with even parity over its eight bits produces `out_byte` = 8'h20 (blank) and `out_bad`=1.
- R3: A Hamming byte (`in_ham`=1) uses these data positions: bit3=d0, bit5=d1, bit6=d2, bit7=d3. The check bits are bit1 = d0^d1^d3, bit2 = d0^d2^d3 and bit4 = d1^d2^d3. Bit 0 makes the parity of all eight bits even. An error-free codeword produces `out_byte` = {4'b0, d3..d0} with no error pulse.
- R4: A Hamming byte with exactly one flipped bit, in any of the eight positions, produces the original nibble with `out_fixed`=1 and `out_bad`=0.
- R5: A Hamming byte with exactly two flipped bits produces `out_byte` = 8'h20 with `out_bad`=1 and `out_fixed`=0.
- R6: After reset, and in the cycle after any `line_start` pulse that comes with no corrupt byte, `line_ok` is 1.
- R7: A repaired or uncorrectable byte drives `line_ok` low in the same cycle as its error pulse. `line_ok` stays low until the next `line_start`. A byte that arrives together with `line_start` counts toward the new line.
- R8: Each accepted byte gives exactly one `out_valid` pulse, one cycle later. A cycle with `in_valid`=0 gives no output pulse and leaves `line_ok` unchanged.
- R9: During and just after reset, `out_valid`, `out_fixed` and `out_bad` are 0, `out_byte` is 0 and `line_ok` is 1.
- R10: `out_fixed` and `out_bad` are never high at the same time, and neither is high without `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte strobe |
| in_byte | input | 8 | Received byte |
| in_ham | input | 1 | 1 = Hamming-protected byte, 0 = parity-protected display byte |
| line_start | input | 1 | One-cycle pulse at the start of each line |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_byte | output | 8 | Checked, repaired or blanked byte |
| out_fixed | output | 1 | Byte had a single-bit error that was repaired |
| out_bad | output | 1 | Byte was uncorrectable and replaced by the blank code |
| line_ok | output | 1 | High while no corrupt byte has been seen on the current line |

## Verification
The properties assume that `line_start` is a single-cycle pulse. They also assume that `in_ham` and `in_byte` only matter while `in_valid` is high. The result checks assume a byte is never corrupted in more than two bits.

The stimulus drives every byte with `in_valid` for exactly one cycle. It builds Hamming faults from valid codewords with exactly one or two bits flipped, and builds display faults by breaking the parity bit only. The bench also places one corrupt byte in the same cycle as `line_start`, so the ordering rule of R7 is exercised.

// File: rtl/txg_pkg.sv
package txg_pkg;

   // Result of checking one byte.
   typedef struct packed {
      logic [7:0] data;
      logic       fixed;
      logic       bad;
   } txg_result_t;

   // Hamming positions 1..7 map to byte bits 1..7; bit 0 is the overall parity.
   localparam int unsigned TXG_SYN_W = 3;

endpackage

// File: rtl/txg_ham_decode.sv
module txg_ham_decode
   import txg_pkg::*;
#(
   parameter bit STRIP_CHECK_BITS = 1'b1
)(
   input  logic [7:0]  code_in,
   output txg_result_t res
);
   logic [TXG_SYN_W-1:0] syn;
   logic                 tot;

   always_comb begin
      syn[0] = code_in[1] ^ code_in[3] ^ code_in[5] ^ code_in[7];
      syn[1] = code_in[2] ^ code_in[3] ^ code_in[6] ^ code_in[7];
      syn[2] = code_in[4] ^ code_in[5] ^ code_in[6] ^ code_in[7];
      tot    = ^code_in;
   end

   // Flip decision for byte bit p: odd total parity points at one bad bit.
   function automatic logic flip_at(input int unsigned p,
                                    input logic [TXG_SYN_W-1:0] s,
                                    input logic t);
      return t && (s == TXG_SYN_W'(p));
   endfunction

   generate
      if (STRIP_CHECK_BITS) begin : g_nibble
         always_comb begin
            res.data = {4'b0000,
                        code_in[7] ^ flip_at(7, syn, tot),
                        code_in[6] ^ flip_at(6, syn, tot),
                        code_in[5] ^ flip_at(5, syn, tot),
                        code_in[3] ^ flip_at(3, syn, tot)};
         end
      end else begin : g_codeword
         always_comb begin
            for (int unsigned k = 0; k < 8; k++)
               res.data[k] = code_in[k] ^ flip_at(k, syn, tot);
         end
      end
   endgenerate

   always_comb begin
      res.fixed = tot;
      res.bad   = !tot && (syn != '0);
   end

   // R4 / R5: a correctable word is never also reported uncorrectable
   always_comb begin
      p_ham_excl_r10: assert (!(res.fixed && res.bad))
         else $error("hamming decode reports both outcomes");
   end
endmodule

// File: rtl/txg_parity_check.sv
module txg_parity_check
   import txg_pkg::*;
#(
   parameter bit ODD_PARITY = 1'b1
)(
   input  logic [7:0]  byte_in,
   output txg_result_t res
);
   logic par_ok;

   generate
      if (ODD_PARITY) begin : g_odd
         assign par_ok = (^byte_in) == 1'b1;
      end else begin : g_even
         assign par_ok = (^byte_in) == 1'b0;
      end
   endgenerate

   always_comb begin
      res.data  = {1'b0, byte_in[6:0]};
      res.fixed = 1'b0;
      res.bad   = !par_ok;
   end
endmodule

// File: rtl/txg_line_flag.sv
module txg_line_flag #(
   parameter bit COUNT_REPAIRED = 1'b1
)(
   input  logic clk,
   input  logic rst_n,
   input  logic line_start,
   input  logic hit_valid,
   input  logic hit_fixed,
   input  logic hit_bad,
   output logic line_ok
);
   logic hit;

   generate
      if (COUNT_REPAIRED) begin : g_any
         assign hit = hit_valid && (hit_fixed || hit_bad);
      end else begin : g_bad_only
         assign hit = hit_valid && hit_bad;
         logic unused_fixed;
         assign unused_fixed = hit_fixed;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)          line_ok <= 1'b1;
      else if (line_start) line_ok <= !hit;
      else if (hit)        line_ok <= 1'b0;
   end

   p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!line_ok && !line_start) |=> !line_ok)
      else $error("line flag recovered without line start");

   p_flag_rearm_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (line_start && !hit_valid) |=> line_ok)
      else $error("line flag not set by line start");
endmodule

// File: rtl/txt_byte_guard.sv
module txt_byte_guard
   import txg_pkg::*;
#(
   parameter logic [7:0] BLANK_CODE     = 8'h20,
   parameter bit         ODD_PARITY     = 1'b1,
   parameter bit         HAM_STRIP      = 1'b1,
   parameter bit         FLAG_REPAIRED  = 1'b1
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       in_valid,
   input  logic [7:0] in_byte,
   input  logic       in_ham,
   input  logic       line_start,
   output logic       out_valid,
   output logic [7:0] out_byte,
   output logic       out_fixed,
   output logic       out_bad,
   output logic       line_ok
);
   generate
      if (BLANK_CODE[7] != 1'b0) begin : g_bad_blank
         $error("BLANK_CODE must be a seven-bit character code");
      end
   endgenerate

   txg_result_t ham_res, par_res, sel_res;

   txg_ham_decode #(.STRIP_CHECK_BITS(HAM_STRIP)) i_ham (
      .code_in (in_byte),
      .res     (ham_res)
   );

   txg_parity_check #(.ODD_PARITY(ODD_PARITY)) i_par (
      .byte_in (in_byte),
      .res     (par_res)
   );

   always_comb begin
      sel_res = in_ham ? ham_res : par_res;
      if (sel_res.bad) sel_res.data = BLANK_CODE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_byte  <= '0;
         out_fixed <= 1'b0;
         out_bad   <= 1'b0;
      end else begin
         out_valid <= in_valid;
         out_fixed <= in_valid && sel_res.fixed;
         out_bad   <= in_valid && sel_res.bad;
         if (in_valid) out_byte <= sel_res.data;
      end
   end

   txg_line_flag #(.COUNT_REPAIRED(FLAG_REPAIRED)) i_flag (
      .clk        (clk),
      .rst_n      (rst_n),
      .line_start (line_start),
      .hit_valid  (in_valid),
      .hit_fixed  (sel_res.fixed),
      .hit_bad    (sel_res.bad),
      .line_ok    (line_ok)
   );

   p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid)
      else $error("accepted byte produced no result");

   p_no_spurious_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid)
      else $error("result without accepted byte");

   p_blank_r5: assert property (@(posedge clk) disable iff (!rst_n)
      out_bad |-> (out_byte == BLANK_CODE))
      else $error("uncorrectable byte not blanked");

   p_pulse_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (out_fixed || out_bad) |-> (out_valid && !(out_fixed && out_bad)))
      else $error("error pulses inconsistent");

   p_flag_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (FLAG_REPAIRED && (out_fixed || out_bad)) |-> !line_ok)
      else $error("corrupt byte left line flag high");
endmodule

// File: tb/test_txt_byte_guard.sv
module test_txt_byte_guard;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic [7:0] in_byte = '0;
   logic       in_ham = 1'b0;
   logic       line_start = 1'b0;
   logic       out_valid, out_fixed, out_bad, line_ok;
   logic [7:0] out_byte;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   txt_byte_guard i_txt_byte_guard (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
      .in_ham(in_ham), .line_start(line_start), .out_valid(out_valid),
      .out_byte(out_byte), .out_fixed(out_fixed), .out_bad(out_bad),
      .line_ok(line_ok)
   );

   function automatic logic [7:0] enc(input logic [3:0] n);
      logic [7:0] c;
      c = '0;
      c[3] = n[0]; c[5] = n[1]; c[6] = n[2]; c[7] = n[3];
      c[1] = n[0] ^ n[1] ^ n[3];
      c[2] = n[0] ^ n[2] ^ n[3];
      c[4] = n[1] ^ n[2] ^ n[3];
      c[0] = ^c[7:1];
      return c;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // Drive one byte for one cycle; results are sampled one cycle later.
   task automatic send(input logic [7:0] b, input logic ham, input logic ls);
      @(negedge clk);
      in_valid = 1'b1; in_byte = b; in_ham = ham; line_start = ls;
      @(negedge clk);
      in_valid = 1'b0; line_start = 1'b0;
   endtask

   task automatic pulse_line();
      @(negedge clk);
      line_start = 1'b1;
      @(negedge clk);
      line_start = 1'b0;
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk("R9 valid", out_valid, 0);
      chk("R9 byte", out_byte, 0);
      chk("R9 pulses", {out_fixed, out_bad}, 0);
      chk("R9 line_ok", line_ok, 1);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R6 line_ok after reset", line_ok, 1);
   endtask

   task automatic t_display();
      logic [7:0] c;
      pulse_line();
      for (int ch = 32; ch < 128; ch += 5) begin
         c = {~(^ch[6:0]), ch[6:0]};
         send(c, 1'b0, 1'b0);
         chk("R1 byte", out_byte, {1'b0, c[6:0]});
         chk("R1 pulses", {out_valid, out_fixed, out_bad}, 3'b100);
      end
      chk("R6 line_ok clean line", line_ok, 1);
      c = {^8'h41 == 1'b0 ? 1'b0 : 1'b1, 7'h41};
      c = {~(^7'h41), 7'h41} ^ 8'h80;
      send(c, 1'b0, 1'b0);
      chk("R2 blank", out_byte, 8'h20);
      chk("R2 pulses", {out_valid, out_fixed, out_bad}, 3'b101);
      chk("R7 drop", line_ok, 0);
   endtask

   task automatic t_ham_clean();
      pulse_line();
      for (int n = 0; n < 16; n++) begin
         send(enc(4'(n)), 1'b1, 1'b0);
         chk("R3 nibble", out_byte, {4'b0, 4'(n)});
         chk("R3 pulses", {out_valid, out_fixed, out_bad}, 3'b100);
      end
      chk("R6 line_ok", line_ok, 1);
   endtask

   task automatic t_ham_single();
      for (int n = 0; n < 16; n++) begin
         for (int p = 0; p < 8; p++) begin
            pulse_line();
            send(enc(4'(n)) ^ (8'h01 << p), 1'b1, 1'b0);
            chk("R4 nibble", out_byte, {4'b0, 4'(n)});
            chk("R4 pulses", {out_valid, out_fixed, out_bad}, 3'b110);
            chk("R7 repaired drops flag", line_ok, 0);
         end
      end
   endtask

   task automatic t_ham_double();
      for (int i = 0; i < 8; i++) begin
         for (int j = i + 1; j < 8; j++) begin
            send(enc(4'hA) ^ (8'h01 << i) ^ (8'h01 << j), 1'b1, 1'b0);
            chk("R5 blank", out_byte, 8'h20);
            chk("R5 pulses", {out_valid, out_fixed, out_bad}, 3'b101);
         end
      end
   endtask

   task automatic t_line_flag();
      pulse_line();
      chk("R6 rearm", line_ok, 1);
      send(enc(4'h3) ^ 8'h03, 1'b1, 1'b0);
      chk("R7 drop", line_ok, 0);
      send(enc(4'h5), 1'b1, 1'b0);
      chk("R7 stays low", line_ok, 0);
      repeat (4) @(negedge clk);
      chk("R8 idle no output", out_valid, 0);
      chk("R7 stays low idle", line_ok, 0);
      // Corrupt byte coincident with line start belongs to the new line.
      send(8'h00, 1'b0, 1'b1);
      chk("R7 coincident", line_ok, 0);
      chk("R2 coincident blank", out_byte, 8'h20);
      pulse_line();
      chk("R6 rearm again", line_ok, 1);
      send(enc(4'h9), 1'b1, 1'b1);
      chk("R6 clean with start", line_ok, 1);
      // Garbage on the byte lines without in_valid is ignored.
      @(negedge clk);
      in_byte = 8'h00; in_ham = 1'b0;
      @(negedge clk);
      chk("R8 ignored valid", out_valid, 0);
      chk("R8 ignored flag", line_ok, 1);
      chk("R8 ignored byte", out_byte, 8'h09);
      chk("R10 ignored pulses", {out_fixed, out_bad}, 0);
   endtask

   initial begin
      t_reset();
      t_display();
      t_ham_clean();
      t_ham_single();
      t_ham_double();
      t_line_flag();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual hung expected done");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule